// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for every cycle of a four-beat burst on a synchronous memory. A load strobe captures a full start address and the burst ordering. Each later advance strobe moves only the two lowest address bits to the next beat. The upper bits stay fixed until the next load. The beat order is either interleaved or linear.

In interleaved order, the low bits are the start bits XOR the beat number. In linear order, they are the start bits plus the beat number, modulo four. After the fourth beat the sequence returns to the start offset. Reads and writes share the same sequence, because the block only sees load and advance strobes.

A clock-enable input freezes the whole block for stalled cycles. The controller is a two-state machine:

- **IDLE** is entered at reset. Nothing has been loaded yet, so an advance is not honoured.
- **ACTIVE** follows the first load. The transition IDLE→ACTIVE happens on a load.
- The transition ACTIVE→ACTIVE happens on a load, which restarts the burst, or on an advance, which steps the beat counter.
- The machine holds its state and counters on any other cycle, and on every cycle with clock enable low.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the address output is all zeros and the block is in IDLE.
- R2: A load with clock enable high makes the address output equal the start address input from the next cycle on, and latches the order select.
- R3: Advances never change address bits above the two low bits; only a load changes them.
- R4: With order select 1 at load (interleaved), beat k shows low bits = start XOR k. A start of 01 gives 01, 00, 11, 10.
- R5: With order select 0 at load (linear), beat k shows low bits = (start + k) mod 4. A start of 10 gives 10, 11, 00, 01.
- R6: The fourth advance after a load returns the low bits to the start offset.
- R7: While clock enable is low, load and advance are ignored and the address output holds.
- R8: When load and advance are both high in one enabled cycle, the load wins and the output shows the new start address.
- R9: The order select is sampled only at load; changing it in the middle of a burst does not alter the sequence.
- R10: An advance in IDLE, before any load, leaves the address output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| load_i | input | 1 | Capture start address and order select |
| adv_i | input | 1 | Step to the next beat of the burst |
| start_addr_i | input | 20 | Start address for the burst |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | 20 | Current burst address |

## Verification
The assertions check four things on every cycle: the upper bits stay fixed across non-load cycles, a load is captured, the output holds under clock-enable low or in IDLE, and each linear advance adds one to the low bits. Some behaviours can only be shown by the bench's scenarios. These are the full interleaved beat sequences, the wrap back to the start after four beats, load winning over advance in the same cycle, and a mid-burst change of the order select being ignored.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } burst_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             order_i,
    output burst_state_t     state_o,
    output logic [OFS_W-1:0] step_o,
    output burst_order_t     order_o
);
    burst_state_t     state_q, state_d;
    logic [OFS_W-1:0] step_q, step_d;
    burst_order_t     order_q, order_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (clk_en) begin
            state_q <= state_d;
            step_q  <= step_d;
            order_q <= order_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        order_d = order_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d = ST_ACTIVE;
                    step_d  = '0;
                    order_d = burst_order_t'(order_i);
                end
            end
            ST_ACTIVE: begin
                if (load_i) begin
                    step_d  = '0;
                    order_d = burst_order_t'(order_i);
                end else if (adv_i) begin
                    step_d = step_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign step_o  = step_q;
    assign order_o = order_q;

    assert_idle_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && !load_i && state_q == ST_IDLE) |=> (step_q == '0));
endmodule

// File: rtl/burst_offset_calc.sv
module burst_offset_calc
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] base_i,
    input  logic [OFS_W-1:0] step_i,
    input  burst_order_t     order_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] ofs_xor, ofs_add;

    assign ofs_xor = base_i ^ step_i;
    assign ofs_add = base_i + step_i;

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: ofs_o = ofs_xor;
            ORD_LINEAR:     ofs_o = ofs_add;
            default:        ofs_o = ofs_add;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              order_sel_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic [UP_W-1:0]  upper_q;
    logic [OFS_W-1:0] base_q;
    logic [OFS_W-1:0] step;
    logic [OFS_W-1:0] ofs;
    burst_state_t     state;
    burst_order_t     order;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            base_q  <= '0;
        end else if (clk_en && load_i) begin
            upper_q <= start_addr_i[ADDR_W-1:OFS_W];
            base_q  <= start_addr_i[OFS_W-1:0];
        end
    end

    burst_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .order_i (order_sel_i),
        .state_o (state),
        .step_o  (step),
        .order_o (order)
    );

    burst_offset_calc #(.OFS_W(OFS_W)) u_ofs (
        .base_i  (base_q),
        .step_i  (step),
        .order_i (order),
        .ofs_o   (ofs)
    );

    assign addr_o = {upper_q, ofs};

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && load_i) |=> (addr_o == $past(start_addr_i)));

    assert_upper_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(clk_en && load_i)) |=> (addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W])));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clk_en) |=> $stable(addr_o));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clk_en && !load_i && adv_i && state == ST_ACTIVE && order == ORD_LINEAR)
        |=> (addr_o[OFS_W-1:0] == OFS_W'($past(addr_o[OFS_W-1:0]) + 1'b1)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load_i && state == ST_IDLE) |=> $stable(addr_o));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic [19:0] start_addr_i = '0;
    logic        order_sel_i = 1'b1;
    logic [19:0] addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en       (clk_en),
        .load_i       (load_i),
        .adv_i        (adv_i),
        .start_addr_i (start_addr_i),
        .order_sel_i  (order_sel_i),
        .addr_o       (addr_o)
    );

    // Monitor: compare each result against the scoreboard queue.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [19:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr_o !== e) begin
                failures++;
                $display("FAIL %s: addr_o=%05h expected=%05h", t, addr_o, e);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the expected address.
    task automatic cyc(input logic en, input logic ld, input logic adv,
                       input logic [19:0] a, input logic ord,
                       input logic [19:0] e, input string t);
        @(negedge clk);
        clk_en = en; load_i = ld; adv_i = adv; start_addr_i = a; order_sel_i = ord;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    function automatic logic [19:0] ilv(logic [19:0] s, int k);
        return {s[19:2], s[1:0] ^ 2'(k)};
    endfunction

    function automatic logic [19:0] lin(logic [19:0] s, int k);
        return {s[19:2], 2'(s[1:0] + 2'(k))};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(1'b1, 1'b0, 1'b0, 20'h0, 1'b1, 20'h00000, "R1");
        // R10 advance while idle
        cyc(1'b1, 1'b0, 1'b1, 20'hFFFFF, 1'b1, 20'h00000, "R10");
        cyc(1'b1, 1'b0, 1'b1, 20'h12345, 1'b0, 20'h00000, "R10");
        // R2/R4 interleaved from 01
        cyc(1'b1, 1'b1, 1'b0, 20'hABCD1, 1'b1, 20'hABCD1, "R2");
        for (int k = 1; k < 4; k++)
            cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, ilv(20'hABCD1, k), "R4");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, 20'hABCD1, "R6");
        // R5 linear from 10, with upper bits checked (R3)
        cyc(1'b1, 1'b1, 1'b0, 20'h12346, 1'b0, 20'h12346, "R2");
        for (int k = 1; k < 4; k++)
            cyc(1'b1, 1'b0, 1'b1, 20'h55555, 1'b0, lin(20'h12346, k), "R5");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b0, 20'h12346, "R6");
        cyc(1'b1, 1'b0, 1'b0, 20'hFFFFF, 1'b0, 20'h12346, "R3");
        // R7 clock enable low ignores load and advance
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b0, 20'h12347, "R5");
        cyc(1'b0, 1'b1, 1'b1, 20'h99998, 1'b1, 20'h12347, "R7");
        cyc(1'b0, 1'b0, 1'b1, 20'h0, 1'b1, 20'h12347, "R7");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, 20'h12344, "R7");
        // R8 load wins over advance
        cyc(1'b1, 1'b1, 1'b1, 20'h7F002, 1'b1, 20'h7F002, "R8");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, 20'h7F003, "R4");
        // R9 order latched at load: linear start 11, flip select mid-burst
        cyc(1'b1, 1'b1, 1'b0, 20'h00003, 1'b0, 20'h00003, "R2");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, 20'h00000, "R9");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b1, 20'h00001, "R9");
        // interleaved start 10, select forced low mid-burst
        cyc(1'b1, 1'b1, 1'b0, 20'hC0DE2, 1'b1, 20'hC0DE2, "R2");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b0, 20'hC0DE3, "R9");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b0, 20'hC0DE0, "R9");
        cyc(1'b1, 1'b0, 1'b1, 20'h0, 1'b0, 20'hC0DE1, "R4");
        @(negedge clk);
        adv_i = 1'b0; load_i = 1'b0;
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule